// File: doc/BRIEF.md
# Three-Stage Cascadable Reload Timer

This block holds three 8-bit down counters, each paired with a reload latch. A stage decrements once per count pulse. When a pulse arrives while the stage already sits at zero, the stage underflows instead. On an underflow it copies its latch back into the counter and raises its own interrupt flag. A stage period is therefore the latch value plus one pulse.

The first stage always counts the internal divide-by-16 tick. Each later stage selects its count pulse with one control bit. The middle stage picks between the first stage's underflow and a separate alternate tick input. The last stage picks between the divide-by-16 tick and the middle stage's underflow. With these selections the stages chain into periods of up to 24 bits.

The middle stage also drives a toggle output. When the output is enabled, the pin is driven and it inverts on every underflow of the middle stage. A byte-wide register port is used to load latches and counters, read back counters, set control bits and clear the interrupt flags.

Top module: `cascade_timer8`

## Requirements
- R1: After reset all three counters read 0xFF, the control register reads 0, the interrupt flags read 0, and `tout_oe` and `tout` are 0.
- R2: Every `tick16` pulse decrements the first counter by one. Its counter is read at address 0. A write to address 0 loads its latch and its counter together.
- R3: A count pulse that arrives while a counter is 0 reloads that counter from its latch. The same pulse sets that stage's flag in the flag register: bit 0 for the first stage, bit 1 for the middle stage, bit 2 for the last stage.
- R4: Control bit 0 selects the count pulse of the middle stage (address 1): 0 means underflow of the first stage, 1 means `alt_tick`. The source that is not selected has no effect.
- R5: Control bit 1 selects the count pulse of the last stage (address 2): 0 means `tick16`, 1 means underflow of the middle stage.
- R6: Control bit 2 sets how a write to address 1 behaves. With the bit at 0, the write loads both the latch and the counter. With the bit at 1, it loads the latch only. The counter keeps counting and picks up the new value at its next reload.
- R7: When control bit 3 is 1, `tout_oe` is 1 and `tout` inverts on each underflow of the middle stage.
- R8: When control bit 3 is 0, `tout_oe` and `tout` are 0. Every write to the control register (address 3) loads the toggle flip-flop with data bit 4. So once the output is enabled, `tout` starts at that level, whatever underflows took place before.
- R9: Writing address 4 clears each flag whose data bit is 1. An underflow in the same cycle as the clear leaves its flag set.
- R10: A counter write in the same cycle as that stage's count pulse takes the written value, and no underflow happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle divide-by-16 count pulse |
| alt_tick | input | 1 | One-cycle alternate count pulse for the middle stage |
| we | input | 1 | Register write strobe |
| waddr | input | 3 | Write address: 0..2 stages, 3 control, 4 flag clear |
| wdata | input | 8 | Write data |
| raddr | input | 3 | Read address: 0..2 counters, 3 control, 4 flags |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 3 | Interrupt flags, one per stage |
| tout | output | 1 | Toggle output level |
| tout_oe | output | 1 | Toggle output enable |

## Verification
There are two collisions between software and an underflow in one cycle. The first is a flag-clear write landing on an underflow. The bench forces it by setting the first stage to a zero latch and zero count, then driving `tick16` in the same cycle as a clear of bit 0. The flag must read 1 afterwards. The second is a counter write landing on that stage's count pulse. The bench writes the last stage while `tick16` is high and expects the written value to read back untouched.

// File: rtl/cascade_timer8.sv
module cascade_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         alt_tick,
  input  logic         we,
  input  logic [2:0]   waddr,
  input  logic [W-1:0] wdata,
  input  logic [2:0]   raddr,
  output logic [W-1:0] rdata,
  output logic [2:0]   irq,
  output logic         tout,
  output logic         tout_oe
);
  localparam logic [2:0] A_S1 = 3'd0, A_S2 = 3'd1, A_S3 = 3'd2, A_CTL = 3'd3, A_IRQ = 3'd4;
  localparam logic [W-1:0] INIT = '1;

  logic [W-1:0] lat1, lat2, lat3, cnt1, cnt2, cnt3;
  logic [4:0]   ctrl;
  logic         ff;

  wire w1 = we && waddr == A_S1;
  wire w2 = we && waddr == A_S2;
  wire w3 = we && waddr == A_S3;
  wire wc = we && waddr == A_CTL;
  wire wi = we && waddr == A_IRQ;
  wire w2_cnt = w2 && !ctrl[2];

  wire p1  = tick16;
  wire uf1 = p1 && cnt1 == '0 && !w1;
  wire p2  = ctrl[0] ? alt_tick : uf1;
  wire uf2 = p2 && cnt2 == '0 && !w2_cnt;
  wire p3  = ctrl[1] ? uf2 : tick16;
  wire uf3 = p3 && cnt3 == '0 && !w3;

  wire [2:0] clr = wi ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat1 <= INIT; lat2 <= INIT; lat3 <= INIT;
      cnt1 <= INIT; cnt2 <= INIT; cnt3 <= INIT;
      ctrl <= '0;
      ff   <= 1'b0;
      irq  <= '0;
    end else begin
      if (w1) begin
        lat1 <= wdata; cnt1 <= wdata;
      end else if (p1) cnt1 <= uf1 ? lat1 : cnt1 - 1'b1;

      if (w2) lat2 <= wdata;
      if (w2_cnt) cnt2 <= wdata;
      else if (p2) cnt2 <= uf2 ? lat2 : cnt2 - 1'b1;

      if (w3) begin
        lat3 <= wdata; cnt3 <= wdata;
      end else if (p3) cnt3 <= uf3 ? lat3 : cnt3 - 1'b1;

      if (wc) begin
        ctrl <= wdata[4:0];
        ff   <= wdata[4];
      end else if (uf2 && ctrl[3]) ff <= ~ff;

      irq <= (irq & ~clr) | {uf3, uf2, uf1};
    end
  end

  always_comb begin
    case (raddr)
      A_S1:    rdata = cnt1;
      A_S2:    rdata = cnt2;
      A_S3:    rdata = cnt3;
      A_CTL:   rdata = W'(ctrl);
      A_IRQ:   rdata = W'(irq);
      default: rdata = '0;
    endcase
  end

  assign tout_oe = ctrl[3];
  assign tout    = ctrl[3] & ff;
endmodule

// File: rtl/cascade_timer8_chk.sv
module cascade_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick16,
  input logic         we,
  input logic [2:0]   waddr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] lat1,
  input logic [2:0]   irq,
  input logic         uf2,
  input logic         tout,
  input logic         tout_oe
);
  wire wr1 = we && waddr == 3'd0;
  wire wrc = we && waddr == 3'd3;

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 && cnt1 != '0 && !wr1 |=> cnt1 == W'($past(cnt1) - 1'b1));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 && cnt1 == '0 && !wr1 |=> cnt1 == $past(lat1) && irq[0]);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tout_oe && uf2 && !wrc |=> tout != $past(tout));

  p_ctl_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrc |=> tout_oe == $past(wdata[3]) && tout == ($past(wdata[3]) && $past(wdata[4])));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we && waddr == 3'd4 && wdata[0] && !(tick16 && cnt1 == '0 && !wr1) |=> !irq[0]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 && cnt1 == '0 && !wr1 |=> irq[0]);
endmodule

bind cascade_timer8 cascade_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .we(we), .waddr(waddr), .wdata(wdata),
  .cnt1(cnt1), .lat1(lat1), .irq(irq), .uf2(uf2), .tout(tout), .tout_oe(tout_oe)
);

// File: tb/cascade_timer8_test.sv
module cascade_timer8_test;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT_ADDR = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick16 = 1'b0, alt_tick = 1'b0, we = 1'b0;
  logic [2:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] irq;
  logic       tout, tout_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int         addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  cascade_timer8 uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .alt_tick(alt_tick),
    .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata),
    .irq(irq), .tout(tout), .tout_oe(tout_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_rd(input int a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic t16 = 1'b0);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d; tick16 = t16;
    @(negedge clk);
    we = 1'b0; tick16 = 1'b0;
  endtask

  task automatic pulse(input bit alt, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (alt) alt_tick = 1'b1; else tick16 = 1'b1;
      @(negedge clk);
      alt_tick = 1'b0; tick16 = 1'b0;
    end
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        it = q[0];
        if (it.addr == TOUT_ADDR) begin
          #1 got = {6'd0, tout_oe, tout};
        end else begin
          raddr = 3'(it.addr);
          #1 got = rdata;
        end
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: addr %0d got %02h expected %02h", it.tag, it.addr, got, it.exp);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(0, 8'hFF, "R1 cnt1");
    expect_rd(1, 8'hFF, "R1 cnt2");
    expect_rd(2, 8'hFF, "R1 cnt3");
    expect_rd(3, 8'h00, "R1 ctrl");
    expect_rd(4, 8'h00, "R1 irq");
    expect_rd(TOUT_ADDR, 8'h00, "R1 tout");

    wr(3'd0, 8'h03);
    pulse(0, 1);
    expect_rd(0, 8'h02, "R2 decrement");
    pulse(0, 2);
    expect_rd(4, 8'h00, "R3 no flag before underflow");
    pulse(0, 1);
    expect_rd(0, 8'h03, "R3 reload");
    expect_rd(4, 8'h01, "R3 flag set");
    expect_rd(1, 8'hFE, "R4 stage2 counts stage1 underflow");
    expect_rd(2, 8'hFB, "R5 stage3 counts tick16");

    wr(3'd4, 8'h01);
    expect_rd(4, 8'h00, "R9 clear");

    wr(3'd2, 8'h10, 1'b1);
    expect_rd(2, 8'h10, "R10 write beats pulse");
    expect_rd(0, 8'h02, "R2 stage1 still counted");

    wr(3'd3, 8'h1A);
    expect_rd(TOUT_ADDR, 8'h03, "R8 start level high");
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h00);
    pulse(0, 2);
    expect_rd(TOUT_ADDR, 8'h02, "R7 toggle low");
    expect_rd(1, 8'h01, "R3 stage2 reload");
    expect_rd(2, 8'h0F, "R5 stage3 counts stage2 underflow");
    expect_rd(4, 8'h03, "R3 flags bits 0 and 1");
    pulse(0, 2);
    expect_rd(TOUT_ADDR, 8'h03, "R7 toggle high");
    expect_rd(2, 8'h0E, "R5 cascade second");

    wr(3'd3, 8'h02);
    expect_rd(TOUT_ADDR, 8'h00, "R8 disabled pin");
    pulse(0, 2);
    expect_rd(TOUT_ADDR, 8'h00, "R8 disabled pin after underflow");
    wr(3'd3, 8'h1A);
    expect_rd(TOUT_ADDR, 8'h03, "R8 reinit level");
    expect_rd(2, 8'h0D, "R5 cascade while pin off");

    wr(3'd3, 8'h05);
    wr(3'd1, 8'h20);
    expect_rd(1, 8'h01, "R6 latch-only write keeps counter");
    pulse(1, 1);
    expect_rd(1, 8'h00, "R4 alt tick counts");
    wr(3'd4, 8'h07);
    pulse(1, 1);
    expect_rd(1, 8'h20, "R6 new latch on reload");
    expect_rd(4, 8'h02, "R3 stage2 flag");
    wr(3'd3, 8'h01);
    expect_rd(3, 8'h01, "R4 ctrl readback");
    wr(3'd1, 8'h05);
    expect_rd(1, 8'h05, "R6 write loads both");
    pulse(0, 1);
    expect_rd(1, 8'h05, "R4 tick16 ignored by stage2");
    expect_rd(2, 8'h0C, "R5 stage3 back on tick16");

    wr(3'd4, 8'h07);
    expect_rd(4, 8'h00, "R9 clear all");
    wr(3'd4, 8'h01, 1'b1);
    expect_rd(4, 8'h01, "R9 set wins over clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule